// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block keeps the tag side of an n-way set-associative cache. It stores no data. Each request brings a block address. The low bits of that address pick a set. The rest of the address is the tag, and it is compared against every way of that set at once. The registered result reports hit or miss and a way number. On a hit, the way number is the matching way. On a miss, it is the way just chosen to receive the new tag, and the tag is installed there in the same cycle the request is taken.

The victim way is picked by a live configuration pin, `cfg_lru`. When it is low, each set refills its ways round-robin. When it is high, the least recently touched way is refilled. A build with one way behaves as a direct-mapped cache: a miss always overwrites the one line of the indexed set. Two running counters, for lookups and for hits, allow the hit ratio to be read off at any time.

Requests use a valid/ready handshake and one lookup is taken per cycle. `req_ready` is low while reset is held and for the first edge after it is released. After that it stays high, so the only back-pressure is during reset. Results have no ready. Each accepted request gives exactly one response pulse one cycle later, and whoever consumes it must take it in that cycle.

Top module: `cache_tag_ctrl`

## Requirements
- R1: The set is `req_addr mod SETS`, which is the low `log2(SETS)` address bits. The tag is `req_addr / SETS`. Equal tags held in different sets never hit for each other.
- R2: A lookup hits exactly when a valid way of the indexed set holds the request tag. `resp_hit` and `resp_miss` are never high together, one of them is high whenever `resp_valid` is high, and on a hit `resp_way` is the matching way.
- R3: Reset clears every valid bit. After reset, the first lookup of any address misses, both counters read 0 and `resp_valid` is low.
- R4: On a miss, if the set has any invalid way, the lowest-numbered invalid way is the victim, whatever the policy.
- R5: With `cfg_lru` = 0 (round-robin), each set keeps a pointer that starts at way 0. After every fill, the pointer moves to the way after the filled one, wrapping from WAYS-1 to 0. Hits leave the pointer unchanged.
- R6: With `cfg_lru` = 1 (least recent), a miss in a full set replaces the valid way whose last access, hit or fill, is the oldest. Every access makes its way the most recent.
- R7: With WAYS = 1, a miss overwrites the single line of the indexed set, and `resp_way` is always 0.
- R8: A request is taken on an edge where `req_valid` and `req_ready` are both high. `resp_valid` is high for exactly one cycle right after each such edge and is low otherwise. `req_ready` is high from the second edge after reset is released.
- R9: `acc_cnt` rises by 1 with each response, and `hit_cnt` rises by 1 with each hit response. Both change in the same cycle as that response, wrap modulo 2^CNT_W, and are otherwise steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_lru | input | 1 | Victim policy: 0 round-robin, 1 least recently used |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W | Block address |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_hit | output | 1 | Result was a hit |
| resp_miss | output | 1 | Result was a miss |
| resp_way | output | WAY_W | Hit way, or victim way on a miss |
| hit_cnt | output | CNT_W | Running hit count |
| acc_cnt | output | CNT_W | Running lookup count |

## Verification
Short directed runs in one set check the exact fill order. In round-robin mode, a hit placed between two misses must not move the refill pointer. In least-recent mode, a hit to the oldest way must protect it from the next refill. Long pseudo-random streams over a small range of tags are run in each policy against a reference model, with idle gaps mixed in; these separate the two policies on full sets, catch set aliasing, and catch stray or missing responses. The same traffic goes to a one-way instance, which confirms direct-mapped overwrite and that a reset forgets every stored line.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  typedef enum logic {
    POL_RROBIN = 1'b0,
    POL_LRU    = 1'b1
  } repl_pol_e;
endpackage

// File: rtl/ctc_tag_array.sv
module ctc_tag_array #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int IDX_W = 2,
  parameter int TAG_W = 8,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] tag,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  output logic [WAYS-1:0]  hit_vec,
  output logic [WAYS-1:0]  valid_vec
);
  logic [TAG_W-1:0] tag_mem [SETS][WAYS];
  logic [WAYS-1:0]  vld     [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
    end else if (fill_en) begin
      vld[set_idx][fill_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_mem[set_idx][fill_way] <= tag;
  end

  always_comb begin
    valid_vec = vld[set_idx];
    for (int w = 0; w < WAYS; w++)
      hit_vec[w] = vld[set_idx][w] && (tag_mem[set_idx][w] == tag);
  end
endmodule

// File: rtl/ctc_repl.sv
module ctc_repl
  import cache_tag_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int IDX_W = 2,
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  repl_pol_e        policy,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [WAYS-1:0]  valid_vec,
  input  logic             acc_en,
  input  logic [WAY_W-1:0] acc_way,
  input  logic             fill_en,
  output logic [WAY_W-1:0] victim
);
  generate
    if (WAYS == 1) begin : g_direct
      assign victim = '0;
    end else begin : g_assoc
      logic [WAY_W-1:0] rr_ptr [SETS];
      logic [WAY_W-1:0] age    [SETS][WAYS];
      logic [WAY_W-1:0] inv_way, old_way;
      logic             any_inv;

      always_comb begin
        any_inv = 1'b0;
        inv_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
          if (!valid_vec[w]) begin
            any_inv = 1'b1;
            inv_way = WAY_W'(w);
          end
        end
        old_way = '0;
        for (int w = 0; w < WAYS; w++)
          if (age[set_idx][w] == WAY_W'(WAYS - 1)) old_way = WAY_W'(w);
        if (any_inv)                victim = inv_way;
        else if (policy == POL_LRU) victim = old_way;
        else                        victim = rr_ptr[set_idx];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < SETS; s++) begin
            rr_ptr[s] <= '0;
            for (int w = 0; w < WAYS; w++) age[s][w] <= WAY_W'(w);
          end
        end else begin
          if (fill_en)
            rr_ptr[set_idx] <= (victim == WAY_W'(WAYS - 1)) ? '0 : victim + 1'b1;
          if (acc_en) begin
            for (int w = 0; w < WAYS; w++) begin
              if (WAY_W'(w) == acc_way)
                age[set_idx][w] <= '0;
              else if (age[set_idx][w] < age[set_idx][acc_way])
                age[set_idx][w] <= age[set_idx][w] + 1'b1;
            end
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ctc_counters.sv
module ctc_counters #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev,
  input  logic             ev_hit,
  output logic [CNT_W-1:0] hit_cnt,
  output logic [CNT_W-1:0] acc_cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_cnt <= '0;
      acc_cnt <= '0;
    end else if (ev) begin
      acc_cnt <= acc_cnt + 1'b1;
      if (ev_hit) hit_cnt <= hit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import cache_tag_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SETS   = 4,
  parameter int WAYS   = 4,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_lru,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_miss,
  output logic [WAY_W-1:0]  resp_way,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic [CNT_W-1:0]  acc_cnt
);
  logic [IDX_W-1:0] set_idx;
  logic [TAG_W-1:0] tag;
  logic [WAYS-1:0]  hit_vec, valid_vec;
  logic [WAY_W-1:0] hit_way, victim, touch_way;
  logic             hit, fire, fill_en;

  assign set_idx   = req_addr[IDX_W-1:0];
  assign tag       = req_addr[ADDR_W-1:IDX_W];
  assign fire      = req_valid && req_ready;
  assign hit       = |hit_vec;
  assign fill_en   = fire && !hit;
  assign touch_way = hit ? hit_way : victim;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  ctc_tag_array #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .TAG_W(TAG_W), .WAY_W(WAY_W)
  ) u_tags (
    .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .tag(tag),
    .fill_en(fill_en), .fill_way(victim),
    .hit_vec(hit_vec), .valid_vec(valid_vec)
  );

  ctc_repl #(
    .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_repl (
    .clk(clk), .rst_n(rst_n), .policy(repl_pol_e'(cfg_lru)),
    .set_idx(set_idx), .valid_vec(valid_vec),
    .acc_en(fire), .acc_way(touch_way), .fill_en(fill_en),
    .victim(victim)
  );

  ctc_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ev(fire), .ev_hit(hit),
    .hit_cnt(hit_cnt), .acc_cnt(acc_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_ready  <= 1'b0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_miss  <= 1'b0;
      resp_way   <= '0;
    end else begin
      req_ready  <= 1'b1;
      resp_valid <= fire;
      resp_hit   <= fire && hit;
      resp_miss  <= fire && !hit;
      if (fire) resp_way <= touch_way;
    end
  end
endmodule

// File: rtl/ctc_checker.sv
module ctc_checker #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic             resp_miss,
  input logic [WAY_W-1:0] resp_way,
  input logic [CNT_W-1:0] hit_cnt,
  input logic [CNT_W-1:0] acc_cnt
);
  AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (resp_hit != resp_miss)); // R2
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> !(resp_hit || resp_miss)); // R2
  AST_WAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (int'(resp_way) < WAYS)); // R2
  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid); // R8
  AST_NO_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !resp_valid); // R8
  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (acc_cnt == CNT_W'($past(acc_cnt) + 1'b1))); // R9
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> $stable(acc_cnt)); // R9
  AST_HIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> (hit_cnt == CNT_W'($past(hit_cnt) + 1'b1))); // R9
  AST_HIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_valid && resp_hit) |-> $stable(hit_cnt)); // R9

  generate
    if (WAYS == 1) begin : g_dm
      AST_DM_WAY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_way == '0)); // R7
    end
  endgenerate
endmodule

bind cache_tag_ctrl ctc_checker #(.WAYS(WAYS), .WAY_W(WAY_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_miss(resp_miss),
  .resp_way(resp_way), .hit_cnt(hit_cnt), .acc_cnt(acc_cnt)
);

// File: tb/tb_cache_tag_ctrl.sv
module tb_cache_tag_ctrl;
  localparam int ADDR_W = 10;
  localparam int SETS   = 4;
  localparam int WAYS   = 4;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_lru = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_ready, resp_valid, resp_hit, resp_miss;
  logic [1:0]        resp_way;
  logic [CNT_W-1:0]  hit_cnt, acc_cnt;
  logic              dm_ready, dm_valid, dm_hit, dm_miss;
  logic [0:0]        dm_way;
  logic [CNT_W-1:0]  dm_hcnt, dm_acnt;

  always #10 clk = ~clk;

  cache_tag_ctrl #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_lru(cfg_lru), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_miss(resp_miss), .resp_way(resp_way),
    .hit_cnt(hit_cnt), .acc_cnt(acc_cnt));

  cache_tag_ctrl #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(1), .CNT_W(CNT_W)) dut_dm (
    .clk(clk), .rst_n(rst_n), .cfg_lru(cfg_lru), .req_valid(req_valid),
    .req_ready(dm_ready), .req_addr(req_addr), .resp_valid(dm_valid),
    .resp_hit(dm_hit), .resp_miss(dm_miss), .resp_way(dm_way),
    .hit_cnt(dm_hcnt), .acc_cnt(dm_acnt));

  typedef struct {
    bit    hit;
    int    way;
    bit    dm_hit;
    string req;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0, errors = 0;
  int exp_acc = 0, exp_hit = 0, exp_dm_hit = 0;
  bit done = 0;

  // reference model of the tag store
  bit mv [SETS][WAYS];
  int mt [SETS][WAYS];
  int mptr [SETS];
  int mstamp [SETS][WAYS];
  int now = 0;
  bit dv [SETS];
  int dt [SETS];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < SETS; s++) begin
      mptr[s] = 0; dv[s] = 0; dt[s] = 0;
      for (int w = 0; w < WAYS; w++) begin
        mv[s][w] = 0; mt[s][w] = 0; mstamp[s][w] = 0;
      end
    end
    exp_acc = 0; exp_hit = 0; exp_dm_hit = 0;
  endtask

  task automatic issue(input int addr, input string req);
    exp_t e;
    int s, t, v;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = ADDR_W'(addr);
    s = addr % SETS;
    t = addr / SETS;
    now++;
    e.req = req;
    e.hit = 0;
    e.way = -1;
    for (int w = 0; w < WAYS; w++)
      if (mv[s][w] && mt[s][w] == t) begin e.hit = 1; e.way = w; end
    if (e.hit) begin
      mstamp[s][e.way] = now;
    end else begin
      v = -1;
      for (int w = WAYS - 1; w >= 0; w--) if (!mv[s][w]) v = w;
      if (v < 0) begin
        if (cfg_lru) begin
          v = 0;
          for (int w = 1; w < WAYS; w++) if (mstamp[s][w] < mstamp[s][v]) v = w;
        end else begin
          v = mptr[s];
        end
      end
      e.way = v;
      mv[s][v] = 1; mt[s][v] = t; mstamp[s][v] = now;
      mptr[s] = (v + 1) % WAYS;
    end
    e.dm_hit = dv[s] && dt[s] == t;
    dv[s] = 1; dt[s] = t;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1 && dm_ready == 1'b1, "R8", "ready after reset", int'(req_ready), 1);
    chk(acc_cnt == 0 && hit_cnt == 0, "R3", "counts after reset", int'(acc_cnt), 0);
    chk(resp_valid == 1'b0, "R3", "resp_valid after reset", int'(resp_valid), 0);
  endtask

  // monitor: compare each result against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (resp_valid) begin
        if (exp_q.size() == 0) begin
          chk(0, "R8", "response with nothing outstanding", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          exp_acc++;
          if (e.hit) exp_hit++;
          if (e.dm_hit) exp_dm_hit++;
          chk(resp_hit == e.hit && resp_miss == !e.hit, e.req, "hit flag", int'(resp_hit), int'(e.hit));
          chk(int'(resp_way) == e.way, e.req, "way", int'(resp_way), e.way);
          chk(int'(acc_cnt) == exp_acc && int'(hit_cnt) == exp_hit, "R9", "hit count",
              int'(hit_cnt), exp_hit);
          chk(dm_valid && dm_hit == e.dm_hit && dm_way == 1'b0, "R7", "direct-mapped hit",
              int'(dm_hit), int'(e.dm_hit));
          chk(int'(dm_hcnt) == exp_dm_hit, "R9", "direct-mapped hit count", int'(dm_hcnt), exp_dm_hit);
        end
      end else begin
        chk(dm_valid == 1'b0, "R8", "idle direct-mapped strobe", int'(dm_valid), 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lfsr;
    model_clear();
    cfg_lru = 1'b0;
    @(negedge clk);
    chk(resp_valid == 1'b0 && req_ready == 1'b0, "R3", "outputs in reset", int'(resp_valid), 0);
    do_reset();

    // R4/R5: fill set 0 in way order, then round-robin refill
    issue(4, "R4"); issue(8, "R4"); issue(12, "R4"); issue(16, "R4");
    issue(8, "R2");
    issue(20, "R5"); issue(24, "R5");
    issue(12, "R5");                 // hit must not move the pointer
    issue(28, "R5");                 // so this refills way 2
    idle(2);
    issue(5, "R1"); issue(28, "R1"); issue(29, "R1"); issue(5, "R1");
    lfsr = 32'h1d;
    for (int i = 0; i < 300; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      if (lfsr % 7 == 0) idle(1);
      issue(lfsr % 40, "R5");
    end
    idle(3);
    chk(exp_q.size() == 0, "R8", "outstanding after round-robin run", exp_q.size(), 0);

    cfg_lru = 1'b1;
    do_reset();
    issue(8, "R3");                  // was resident before reset: must miss
    issue(4, "R6"); issue(12, "R6"); issue(16, "R6");
    issue(8, "R6");                  // refresh the oldest way
    issue(20, "R6");                 // evicts address 4
    issue(12, "R6");
    issue(24, "R6");
    issue(4, "R6");
    lfsr = 32'h5a;
    for (int i = 0; i < 300; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      if (lfsr % 5 == 0) idle(1);
      issue(lfsr % 40, "R6");
    end
    idle(3);
    chk(exp_q.size() == 0, "R8", "outstanding after least-recent run", exp_q.size(), 0);
    chk(int'(dm_acnt) == exp_acc, "R9", "direct-mapped lookup count", int'(dm_acnt), exp_acc);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule